// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port driven through a small synchronous register port (word address, write enable, write data, combinational read data). Software uses it to make each pin an input or an output, to pick push-pull or drive-low-only behaviour for outputs, to set output levels and to read pin levels. Each pin's pad input goes through a two-flop synchronizer and then through a per-pin input-buffer gate.

Every pin also watches its own synchronized level for edges. An edge is latched into a per-pin event bit. A per-pin edge-control bit chooses whether only falling edges count or both directions count. There is no rising-only choice. Event bits are cleared by writing ones. The latched events are masked per pin and ORed into a single level interrupt line, which stays high until software clears every enabled event.

The register space is bit-reversed with respect to pin numbers: pin n lives in bit (31 - n) of every per-pin register, so pin 0 is the most significant bit. The word addresses are 0 direction, 1 drive-low-only select, 2 data, 3 event, 4 mask, 5 edge control and 6 input-buffer enable. Every other word address is unmapped.

Top module: `pio_edge_irq`

## Requirements
- R1: After reset every register reads zero. Every pin is an input with its output enable low, and the interrupt is low.
- R2: Pin n maps to bit (31 - n) of every per-pin register, so pin 0 is bit 31 and pin 31 is bit 0.
- R3: A direction bit of 1 makes the pin an output. With the drive-low-only bit clear, the output enable is high and the pad output follows the data bit. A direction bit of 0 keeps the output enable low.
- R4: On an output pin whose drive-low-only bit (word 1) is 1, the pad output is low. The output enable is high only while the data bit is 0, so a data bit of 1 releases the pad.
- R5: Reading the data register (word 2) returns the written data bit for output pins and the synchronized, buffer-gated pad level for input pins.
- R6: Writing the event register (word 3) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: With an edge-control bit (word 5) of 0, both rising and falling edges of the pin set its event bit. With a 1, only falling edges set it.
- R8: The interrupt is high exactly while some pin has both its event bit and its mask bit (word 4) set. A set event on a masked-off pin leaves the interrupt low.
- R9: A write to an unmapped word address (7 and above) changes no register, and a read from one returns zero.
- R10: When an edge is detected on a pin in the same cycle as a write of 1 to that pin's event bit, the event bit remains set.
- R11: While a pin's input-buffer enable bit (word 6) is 0, its data read value as an input is 0 and its edges set no event. Enabling the buffer on a pin already held high records no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| pad_in | input | 32 | Pad input levels, index = pin number |
| pad_out | output | 32 | Pad output levels, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| irq | output | 1 | Level interrupt, high while an enabled event is pending |

## Verification
A wrong event bit shows up on the interrupt line in the same cycle when that pin is unmasked, and in the event word on the next read. An event that is lost or cleared by mistake therefore shows up no later than the next register access. A fault in the synchronizer or in the edge tracking appears as a missing or extra event about three clock edges after a pad change. A fault in the bit reversal or in the drive-low-only logic shows immediately on the pad output and output-enable ports after the configuring write. The same-cycle clear-and-edge case is driven at the exact edge where the synchronized change meets the clear strobe.

// File: rtl/pio_pkg.sv
package pio_pkg;

   // Word addresses of the register port
   typedef enum logic [2:0] {
      RG_DIR = 3'd0,
      RG_ODR = 3'd1,
      RG_DAT = 3'd2,
      RG_EVT = 3'd3,
      RG_MSK = 3'd4,
      RG_ECR = 3'd5,
      RG_IBE = 3'd6
   } reg_sel_e;

   localparam int unsigned REG_COUNT = 7;
   localparam int unsigned MIN_ADDR_W = $clog2(REG_COUNT);

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pio_evt.sv
module pio_evt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_in,
   input  logic [W-1:0] ibe,
   input  logic [W-1:0] ecr,
   input  logic [W-1:0] w1c,
   output logic [W-1:0] evt,
   output logic [W-1:0] smp
);

   logic [W-1:0] prev_q;
   logic [W-1:0] evt_q;
   logic [W-1:0] hit;

   // previous level follows the raw synchronized input, so toggling the
   // buffer enable never fabricates an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_in;
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic chg;
      assign chg    = sync_in[b] ^ prev_q[b];
      assign hit[b] = ibe[b] & chg & (ecr[b] ? prev_q[b] : 1'b1);

      // R6: an event bit only drops after a clear strobe on that bit
      p_clear_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(evt_q[b]) |-> $past(w1c[b]));

      // R10: a detected edge always leaves the bit set, clear or not
      p_keep_on_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(hit[b]) |-> evt_q[b]);

      // R11: no event rises while the input buffer is disabled
      p_gate_ibe_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(evt_q[b]) |-> $past(ibe[b]));

      // R7: in falling-only mode a new event needs a high-to-low change
      p_fall_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(evt_q[b]) && $past(ecr[b])) |-> $past(prev_q[b] && !sync_in[b]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (evt_q & ~w1c) | hit;
   end

   assign evt = evt_q;
   assign smp = sync_in & ibe;

endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
   import pio_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  evt,
   input  logic [W-1:0]  smp,
   output logic [W-1:0]  dir,
   output logic [W-1:0]  odr,
   output logic [W-1:0]  dat,
   output logic [W-1:0]  msk,
   output logic [W-1:0]  ecr,
   output logic [W-1:0]  ibe,
   output logic [W-1:0]  w1c,
   output logic [W-1:0]  rdata
);

   if (AW < MIN_ADDR_W) begin : g_bad_aw
      $error("pio_regfile: AW too small for the register map");
   end

   logic mapped;
   assign mapped = (addr < AW'(REG_COUNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir <= '0;
         odr <= '0;
         dat <= '0;
         msk <= '0;
         ecr <= '0;
         ibe <= '0;
      end else if (we) begin
         case (addr)
            AW'(RG_DIR): dir <= wdata;
            AW'(RG_ODR): odr <= wdata;
            AW'(RG_DAT): dat <= wdata;
            AW'(RG_MSK): msk <= wdata;
            AW'(RG_ECR): ecr <= wdata;
            AW'(RG_IBE): ibe <= wdata;
            default: ;
         endcase
      end
   end

   assign w1c = (we && addr == AW'(RG_EVT)) ? wdata : '0;

   always_comb begin
      case (addr)
         AW'(RG_DIR): rdata = dir;
         AW'(RG_ODR): rdata = odr;
         AW'(RG_DAT): rdata = (dir & dat) | (~dir & smp);
         AW'(RG_EVT): rdata = evt;
         AW'(RG_MSK): rdata = msk;
         AW'(RG_ECR): rdata = ecr;
         AW'(RG_IBE): rdata = ibe;
         default:     rdata = '0;
      endcase
   end

   // R9: unmapped reads return zero
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (rdata == '0));

   // R9: unmapped writes touch no stored register
   p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !mapped) |=> ($stable(dir) && $stable(odr) && $stable(dat) &&
                           $stable(msk) && $stable(ecr) && $stable(ibe)));

endmodule

// File: rtl/pio_edge_irq.sv
module pio_edge_irq
   import pio_pkg::*;
#(
   parameter int unsigned NPIN        = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NPIN-1:0]   bus_wdata,
   output logic [NPIN-1:0]   bus_rdata,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe,
   output logic              irq
);

   if (NPIN < 1 || NPIN > 64) begin : g_bad_npin
      $error("pio_edge_irq: NPIN out of range");
   end

   // all internal vectors are kept in register bit order
   logic [NPIN-1:0] in_reg, sync_reg, smp, evt, w1c;
   logic [NPIN-1:0] dir, odr, dat, msk, ecr, ibe;
   logic [NPIN-1:0] out_reg, oe_reg;

   for (genvar n = 0; n < NPIN; n++) begin : g_pin
      localparam int unsigned BIT = NPIN - 1 - n;
      assign in_reg[BIT] = pad_in[n];
      assign pad_out[n]  = out_reg[BIT];
      assign pad_oe[n]   = oe_reg[BIT];

      // R3: a pin configured as input never drives its pad
      p_oe_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !dir[BIT] |-> !pad_oe[n]);

      // R4: a drive-low-only pin never drives high
      p_od_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (odr[BIT] && pad_oe[n]) |-> !pad_out[n]);
   end

   pio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (in_reg),
      .q     (sync_reg)
   );

   pio_evt #(.W(NPIN)) i_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_reg),
      .ibe     (ibe),
      .ecr     (ecr),
      .w1c     (w1c),
      .evt     (evt),
      .smp     (smp)
   );

   pio_regfile #(.W(NPIN), .AW(ADDR_W)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .we    (bus_we),
      .wdata (bus_wdata),
      .evt   (evt),
      .smp   (smp),
      .dir   (dir),
      .odr   (odr),
      .dat   (dat),
      .msk   (msk),
      .ecr   (ecr),
      .ibe   (ibe),
      .w1c   (w1c),
      .rdata (bus_rdata)
   );

   assign out_reg = dat & ~odr;
   assign oe_reg  = dir & ~(odr & dat);
   assign irq     = |(evt & msk);

   // R8: the interrupt only rises after an event or mask change
   p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !($stable(evt) && $stable(msk)));

endmodule

// File: tb/test_pio_edge_irq.sv
module test_pio_edge_irq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pio_edge_irq i_pio_edge_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .irq       (irq)
   );

   typedef struct packed {
      logic        wr;
      logic [3:0]  adr;
      logic [31:0] dat;
      logic [31:0] pad;
      logic [31:0] exp;
      logic        xirq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VTAB [NV] = '{
      '{1'b0, 4'd0, 32'h0,        32'h0, 32'h0,        1'b0, 4'd1},  // R1 direction
      '{1'b0, 4'd3, 32'h0,        32'h0, 32'h0,        1'b0, 4'd1},  // R1 events
      '{1'b0, 4'd6, 32'h0,        32'h0, 32'h0,        1'b0, 4'd1},  // R1 buffer enable
      '{1'b1, 4'd6, 32'hFFFFFFFF, 32'h0, 32'h0,        1'b0, 4'd11}, // R11 enable buffers
      '{1'b0, 4'd2, 32'h0,        32'h1, 32'h80000000, 1'b0, 4'd2},  // R2 R5 pin0 is bit31
      '{1'b0, 4'd3, 32'h0,        32'h1, 32'h80000000, 1'b0, 4'd7},  // R7 rising counted
      '{1'b1, 4'd4, 32'h80000000, 32'h1, 32'h0,        1'b1, 4'd8},  // R8 unmask
      '{1'b1, 4'd3, 32'h40000000, 32'h1, 32'h0,        1'b1, 4'd6},  // R6 other bit
      '{1'b0, 4'd3, 32'h0,        32'h1, 32'h80000000, 1'b1, 4'd6},  // R6 kept
      '{1'b1, 4'd3, 32'h80000000, 32'h1, 32'h0,        1'b0, 4'd6},  // R6 cleared
      '{1'b1, 4'd5, 32'h80000000, 32'h1, 32'h0,        1'b0, 4'd7},  // R7 falling only
      '{1'b0, 4'd3, 32'h0,        32'h0, 32'h80000000, 1'b1, 4'd7},  // R7 fall seen
      '{1'b1, 4'd3, 32'h80000000, 32'h0, 32'h0,        1'b0, 4'd6},  // R6 clear
      '{1'b0, 4'd3, 32'h0,        32'h1, 32'h0,        1'b0, 4'd7},  // R7 rise ignored
      '{1'b1, 4'd0, 32'h000000FF, 32'h1, 32'h0,        1'b0, 4'd3},  // R3 pins 24..31 out
      '{1'b1, 4'd2, 32'h000000A5, 32'h1, 32'h0,        1'b0, 4'd5},  // R5 data latch
      '{1'b0, 4'd2, 32'h0,        32'h1, 32'h800000A5, 1'b0, 4'd5},  // R5 mixed read
      '{1'b1, 4'd7, 32'hFFFFFFFF, 32'h1, 32'h0,        1'b0, 4'd9},  // R9 unmapped write
      '{1'b0, 4'd7, 32'h0,        32'h1, 32'h0,        1'b0, 4'd9},  // R9 unmapped read
      '{1'b0, 4'd0, 32'h0,        32'h1, 32'h000000FF, 1'b0, 4'd9}   // R9 direction intact
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         pad_in = VTAB[i].pad;
         if (VTAB[i].wr) wr_reg(VTAB[i].adr, VTAB[i].dat);
         else @(negedge clk);
         repeat (4) @(negedge clk);
         bus_addr = VTAB[i].adr;
         #1;
         if (!VTAB[i].wr)
            chk($sformatf("R%0d row %0d rdata", VTAB[i].req, i), bus_rdata, VTAB[i].exp);
         chk($sformatf("R%0d row %0d irq", VTAB[i].req, i), {31'b0, irq}, {31'b0, VTAB[i].xirq});
         @(negedge clk);
      end

      // R3 R2: push-pull outputs on pins 24..31, data 0xA5
      #1;
      chk("R3 pad_oe", pad_oe, 32'hFF000000);
      chk("R3 pad_out", pad_out & pad_oe, 32'hA5000000);

      // R4: drive-low-only on the same pins
      wr_reg(4'd1, 32'h000000FF);
      #1;
      chk("R4 pad_oe", pad_oe, 32'h5A000000);
      chk("R4 pad_out", pad_out & pad_oe, 32'h0);
      @(negedge clk);

      // R11: buffers off, pins 1..15 rise
      wr_reg(4'd6, 32'h0);
      pad_in = 32'h0000FFFF;
      repeat (5) @(negedge clk);
      rd_chk("R11 no events", 4'd3, 32'h0);
      rd_chk("R11 data gated", 4'd2, 32'h000000A5);
      @(negedge clk);
      wr_reg(4'd6, 32'hFFFFFFFF);
      repeat (5) @(negedge clk);
      rd_chk("R11 enable high pin", 4'd3, 32'h0);
      rd_chk("R5 inputs visible", 4'd2, 32'hFFFF00A5);
      @(negedge clk);

      // R7: pin1 falls with both-edge mode
      pad_in = 32'h0000FFFD;
      repeat (5) @(negedge clk);
      rd_chk("R7 pin1 fall", 4'd3, 32'h40000000);
      chk("R8 masked off", {31'b0, irq}, 32'h0);
      @(negedge clk);

      // R10: pin1 rises; clear strobe lands on the edge that latches it
      pad_in = 32'h0000FFFF;
      @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_reg(4'd3, 32'h40000000);
      rd_chk("R10 edge beats clear", 4'd3, 32'h40000000);
      @(negedge clk);
      wr_reg(4'd3, 32'h40000000);
      rd_chk("R6 final clear", 4'd3, 32'h0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule